// File: doc/BRIEF.md
# Cycling Shuffle Bitonic Merger

This block merges two sorted files of keys into one sorted sequence using a single row of compare-exchange cells. Each cell handles one adjacent pair of slots. The row is fed back through a perfect-shuffle rewiring. Both files hold `HALF` keys each, and the block keeps all `2*HALF` keys in one register bank.

A load pulse, taken while the block is idle, fills the bank as follows:
- The first file goes into the lower half of the bank as given.
- The second file goes into the upper half in reversed index order. The bank therefore holds an ascending run followed by a descending run.

On every following clock the bank is shuffled, passed through the comparator row, and written back. Every stage of this merge has its comparators in the same positions, so the same hardware serves each stage. After `log2(2*HALF)` such passes the bank holds the merged result in ascending order and a one-cycle done pulse is raised. The bank then holds its value until the next accepted load.

Top module: `shuffle_merge`

## Requirements
- R1: While reset is high, and in the cycle after it, `busy_o` and `done_o` are low and every key of `keys_o` reads zero.
- R2: A load taken while idle raises `busy_o` one cycle later. In that cycle, slot j (j from 0 to HALF-1) holds element j of `file_a_i`, and slot 2*HALF-1-j holds element j of `file_b_i`. Element j of a port is bits [j*KEY_W +: KEY_W], and slot s of `keys_o` is bits [s*KEY_W +: KEY_W].
- R3: Each pass works in two steps.
  - It first shuffles the bank: slot 2i takes old slot i and slot 2i+1 takes old slot i+HALF.
  - It then compare-exchanges every pair (2i, 2i+1) as unsigned keys. The smaller key goes to the even slot, and equal keys stay in place.
- R4: Exactly log2(2*HALF) passes follow an accepted load. `done_o` is high for exactly the one cycle after the last pass, and `busy_o` falls in that same cycle.
- R5: When `done_o` is high, `keys_o` holds the keys of both files in ascending order from slot 0 upward. This holds for any two ascending input files.
- R6: A load pulse that arrives while `busy_o` is high has no effect on the passes or on the final result.
- R7: While idle with no load, `keys_o` holds its value and `done_o` stays low after its single pulse.
- R8: Duplicate keys, inside one file or across both files, come out in sorted order with every copy kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load request; taken only while idle |
| file_a_i | input | HALF*KEY_W | First sorted file, ascending |
| file_b_i | input | HALF*KEY_W | Second sorted file, ascending as presented |
| busy_o | output | 1 | High while passes are running |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| keys_o | output | 2*HALF*KEY_W | Current contents of the key bank |

## Verification
All checks count clock edges from the edge that samples the load:
- The seeded bank and `busy_o` are due one edge after the load.
- The image after the first shuffle-and-compare pass is due one edge later.
- `done_o` and the merged keys are due log2(2*HALF) edges after the load edge, and `done_o` must fall again one edge after that.

The bench drives inputs and samples outputs on the falling edge, so each check lands midway between the edges that produced the value and the edges that follow. Every check before the last pass also confirms that `done_o` is still low.

// File: rtl/smerge_pkg.sv
package smerge_pkg;

    // Controller phase
    typedef enum logic [0:0] {
        CTL_IDLE = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_state_e;

    // Command from controller to the key bank
    typedef struct packed {
        logic capture;   // seed bank from the two input files
        logic advance;   // write back one shuffle + compare pass
    } bank_cmd_t;

    // Perfect shuffle: source slot feeding destination slot dst
    function automatic int unsigned shuffle_src(input int unsigned dst,
                                                input int unsigned half);
        if ((dst & 32'd1) == 32'd0)
            return dst / 2;
        else
            return dst / 2 + half;
    endfunction

endpackage

// File: rtl/smerge_shuffle.sv
module smerge_shuffle
    import smerge_pkg::*;
#(
    parameter int unsigned HALF  = 4,
    parameter int unsigned KEY_W = 8
) (
    input  logic [2*HALF*KEY_W-1:0] keys_i,
    output logic [2*HALF*KEY_W-1:0] keys_o
);
    localparam int unsigned TOTAL = 2 * HALF;

    // Pure wiring: interleave lower and upper halves
    for (genvar d = 0; d < TOTAL; d++) begin : g_lane
        localparam int unsigned SRC = shuffle_src(d, HALF);
        assign keys_o[d*KEY_W +: KEY_W] = keys_i[SRC*KEY_W +: KEY_W];
    end

endmodule

// File: rtl/smerge_cmpx.sv
module smerge_cmpx #(
    parameter int unsigned KEY_W = 8
) (
    input  logic [KEY_W-1:0] lo_i,
    input  logic [KEY_W-1:0] hi_i,
    output logic [KEY_W-1:0] lo_o,
    output logic [KEY_W-1:0] hi_o
);
    logic swap;

    // Strictly-less test: equal keys are left in place
    assign swap = (hi_i < lo_i);
    assign lo_o = swap ? hi_i : lo_i;
    assign hi_o = swap ? lo_i : hi_i;

endmodule

// File: rtl/smerge_layer.sv
module smerge_layer #(
    parameter int unsigned HALF  = 4,
    parameter int unsigned KEY_W = 8
) (
    input  logic [2*HALF*KEY_W-1:0] keys_i,
    output logic [2*HALF*KEY_W-1:0] keys_o
);
    // One ascending compare-exchange cell per adjacent pair
    for (genvar p = 0; p < HALF; p++) begin : g_pair
        smerge_cmpx #(.KEY_W(KEY_W)) u_cell (
            .lo_i (keys_i[(2*p)*KEY_W   +: KEY_W]),
            .hi_i (keys_i[(2*p+1)*KEY_W +: KEY_W]),
            .lo_o (keys_o[(2*p)*KEY_W   +: KEY_W]),
            .hi_o (keys_o[(2*p+1)*KEY_W +: KEY_W])
        );
    end

endmodule

// File: rtl/smerge_ctrl.sv
module smerge_ctrl
    import smerge_pkg::*;
#(
    parameter int unsigned STAGES = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load_i,
    output bank_cmd_t cmd_o,
    output logic      busy_o,
    output logic      done_o
);
    localparam int unsigned CNT_W = (STAGES > 1) ? $clog2(STAGES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STAGES - 1);

    ctl_state_e       state_q;
    logic [CNT_W-1:0] pass_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CTL_IDLE;
            pass_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                CTL_IDLE: begin
                    if (load_i) begin
                        state_q <= CTL_RUN;
                        pass_q  <= '0;
                    end
                end
                CTL_RUN: begin
                    // Loads are not looked at here: ignored while running
                    pass_q <= pass_q + CNT_W'(1);
                    if (pass_q == LAST) begin
                        state_q <= CTL_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= CTL_IDLE;
            endcase
        end
    end

    assign cmd_o.capture = (state_q == CTL_IDLE) && load_i;
    assign cmd_o.advance = (state_q == CTL_RUN);
    assign busy_o        = (state_q == CTL_RUN);
    assign done_o        = done_q;

endmodule

// File: rtl/shuffle_merge.sv
module shuffle_merge
    import smerge_pkg::*;
#(
    parameter int unsigned HALF  = 4,
    parameter int unsigned KEY_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_i,
    input  logic [HALF*KEY_W-1:0]   file_a_i,
    input  logic [HALF*KEY_W-1:0]   file_b_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [2*HALF*KEY_W-1:0] keys_o
);
    localparam int unsigned TOTAL  = 2 * HALF;
    localparam int unsigned STAGES = $clog2(TOTAL);
    localparam int unsigned BANK_W = TOTAL * KEY_W;

    bank_cmd_t         cmd;
    logic [BANK_W-1:0] bank_q;
    logic [BANK_W-1:0] seeded;
    logic [BANK_W-1:0] shuffled;
    logic [BANK_W-1:0] layered;

    // Seed image: file A straight, file B mirrored -> ascending then descending
    for (genvar j = 0; j < HALF; j++) begin : g_seed
        assign seeded[j*KEY_W +: KEY_W]             = file_a_i[j*KEY_W +: KEY_W];
        assign seeded[(TOTAL-1-j)*KEY_W +: KEY_W]   = file_b_i[j*KEY_W +: KEY_W];
    end

    smerge_ctrl #(.STAGES(STAGES)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_i),
        .cmd_o  (cmd),
        .busy_o (busy_o),
        .done_o (done_o)
    );

    smerge_shuffle #(.HALF(HALF), .KEY_W(KEY_W)) u_shuffle (
        .keys_i (bank_q),
        .keys_o (shuffled)
    );

    smerge_layer #(.HALF(HALF), .KEY_W(KEY_W)) u_layer (
        .keys_i (shuffled),
        .keys_o (layered)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bank_q <= '0;
        else if (cmd.capture)
            bank_q <= seeded;
        else if (cmd.advance)
            bank_q <= layered;
    end

    assign keys_o = bank_q;

endmodule

// File: rtl/shuffle_merge_checker.sv
module shuffle_merge_checker #(
    parameter int unsigned HALF   = 4,
    parameter int unsigned KEY_W  = 8,
    parameter int unsigned STAGES = 3
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    load_i,
    input logic                    busy_o,
    input logic                    done_o,
    input logic [2*HALF*KEY_W-1:0] keys_o
);
    localparam int unsigned TOTAL = 2 * HALF;
    localparam int unsigned RUN_W = $clog2(STAGES + 2);

    // Length of the current busy run, counted independently of the controller
    logic [RUN_W-1:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)
            run_len <= '0;
        else if (busy_o)
            run_len <= run_len + RUN_W'(1);
        else
            run_len <= '0;
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && (keys_o == '0)));

    a_r2_load_starts: assert property (@(posedge clk) disable iff (rst)
        (load_i && !busy_o) |=> busy_o);

    a_r4_pass_count: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (run_len == RUN_W'(STAGES)));

    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r4_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    a_r6_busy_runs_on: assert property (@(posedge clk) disable iff (rst)
        (busy_o && (run_len < RUN_W'(STAGES - 1))) |=> busy_o);

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !load_i) |=> $stable(keys_o));

    for (genvar i = 0; i < TOTAL - 1; i++) begin : g_order
        a_r5_sorted: assert property (@(posedge clk) disable iff (rst)
            done_o |-> (keys_o[i*KEY_W +: KEY_W] <= keys_o[(i+1)*KEY_W +: KEY_W]));
    end

endmodule

bind shuffle_merge shuffle_merge_checker #(
    .HALF   (HALF),
    .KEY_W  (KEY_W),
    .STAGES (STAGES)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .load_i (load_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .keys_o (keys_o)
);

// File: tb/shuffle_merge_tb_top.sv
`timescale 1ns/1ps
module shuffle_merge_tb_top;
    localparam int H = 4;
    localparam int W = 4;
    localparam int T = 2 * H;
    localparam int S = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           load = 1'b0;
    logic [H*W-1:0] fa = '0;
    logic [H*W-1:0] fb = '0;
    logic           busy;
    logic           done;
    logic [T*W-1:0] keys;

    int checks = 0;
    int errors = 0;
    int ka[H];
    int kb[H];
    logic [T*W-1:0] exp_init, exp_pass1, exp_sorted;

    always #2.5 clk = ~clk;

    shuffle_merge #(.HALF(H), .KEY_W(W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .file_a_i (fa),
        .file_b_i (fb),
        .busy_o   (busy),
        .done_o   (done),
        .keys_o   (keys)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic build_expect();
        int init_e[T];
        int srt[T];
        for (int i = 0; i < H; i++) begin
            init_e[i]       = ka[i];
            init_e[T-1-i]   = kb[i];
            fa[i*W +: W]    = W'(ka[i]);
            fb[i*W +: W]    = W'(kb[i]);
        end
        for (int i = 0; i < T; i++) exp_init[i*W +: W] = W'(init_e[i]);
        // first pass: interleave halves, then min to even slot
        for (int i = 0; i < H; i++) begin
            int x = init_e[i];
            int y = init_e[i+H];
            exp_pass1[(2*i)*W   +: W] = W'((x < y) ? x : y);
            exp_pass1[(2*i+1)*W +: W] = W'((x < y) ? y : x);
        end
        for (int i = 0; i < T; i++) srt[i] = init_e[i];
        for (int i = 1; i < T; i++) begin
            for (int j = i; j > 0; j--) begin
                if (srt[j] < srt[j-1]) begin
                    int tmp = srt[j];
                    srt[j] = srt[j-1];
                    srt[j-1] = tmp;
                end
            end
        end
        for (int i = 0; i < T; i++) exp_sorted[i*W +: W] = W'(srt[i]);
    endtask

    task automatic run_merge(input bit poke, input string res_req);
        build_expect();
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
        check(busy == 1'b1 && done == 1'b0, "R2", {62'd0, busy, done}, 64'd2);
        check(keys == exp_init, "R2", 64'(keys), 64'(exp_init));
        if (poke) begin
            load = 1'b1;           // R6: must be ignored while busy
            fa   = ~fa;
            fb   = '0;
        end
        @(negedge clk); load = 1'b0;
        check(keys == exp_pass1, "R3", 64'(keys), 64'(exp_pass1));
        check(done == 1'b0 && busy == 1'b1, "R4", {62'd0, busy, done}, 64'd2);
        for (int s = 2; s < S; s++) begin
            @(negedge clk);
            check(done == 1'b0 && busy == 1'b1, "R4", {62'd0, busy, done}, 64'd2);
        end
        @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, "R4", {62'd0, busy, done}, 64'd1);
        check(keys == exp_sorted, res_req, 64'(keys), 64'(exp_sorted));
        @(negedge clk);
        check(done == 1'b0, "R7", {63'd0, done}, 64'd0);
        check(keys == exp_sorted, "R7", 64'(keys), 64'(exp_sorted));
    endtask

    function automatic bit ascending4(input int v);
        for (int k = 0; k < 3; k++)
            if (((v >> (2*k)) & 3) > ((v >> (2*k+2)) & 3)) return 1'b0;
        return 1'b1;
    endfunction

    initial begin : watchdog
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0 && done == 1'b0, "R1", {62'd0, busy, done}, 64'd0);
        check(keys == '0, "R1", 64'(keys), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && keys == '0, "R1", 64'(keys), 64'd0);

        // Fixed wide-value cases, some with loads poked while busy (R6)
        ka = '{1, 5, 9, 15}; kb = '{0, 7, 8, 14}; run_merge(1'b1, "R6");
        ka = '{0, 1, 2, 3};  kb = '{12, 13, 14, 15}; run_merge(1'b0, "R5");
        ka = '{12, 13, 14, 15}; kb = '{0, 1, 2, 3}; run_merge(1'b1, "R6");
        ka = '{15, 15, 15, 15}; kb = '{15, 15, 15, 15}; run_merge(1'b0, "R8");
        ka = '{3, 3, 9, 9};  kb = '{3, 9, 9, 10}; run_merge(1'b1, "R8");

        // R5/R8 sweep: every pair of ascending 2-bit files (many duplicates)
        for (int xa = 0; xa < 256; xa++) begin
            if (ascending4(xa)) begin
                for (int xb = 0; xb < 256; xb++) begin
                    if (ascending4(xb)) begin
                        for (int k = 0; k < H; k++) begin
                            ka[k] = (xa >> (2*k)) & 3;
                            kb[k] = (xb >> (2*k)) & 3;
                        end
                        run_merge(((xa ^ xb) & 1) == 1, "R5");
                    end
                end
            end
        end

        // R7: long idle, keys stay put, done stays low
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            check(done == 1'b0 && keys == exp_sorted, "R7", 64'(keys), 64'(exp_sorted));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule